// File: doc/BRIEF.md
# DC-Balance Lane Encoder

This block sits in front of a three-lane serial link that is AC-coupled. Every parallel clock it takes a 21-bit word and splits it into three 7-bit groups. Each group becomes a 9-bit lane word, and each lane keeps the running count of ones minus zeros it has sent. When sending a group unchanged would push that count further from zero, the group is inverted. A complementary flag pair in front of the group tells the far end whether to undo the inversion.

A fourth 9-bit word drives the clock lane. Its high time alternates between four and five bit times on successive parallel periods, so that lane also stays balanced. All four words are registered. They are handed in parallel to external shift registers, which send bit 8 first.

Top module: `dcb_lane_encoder`

## Requirements
- R1: Input bits 0-6, 7-13 and 14-20 feed lanes 0, 1 and 2. Lane k appears on `lanes_o[9k+8:9k]`. Within a lane word, bit 8 is flag A, bit 7 is flag B, and bits 6..0 carry data bits 6..0, possibly inverted.
- R2: Flag A is 1 exactly when the data bits of that word are inverted, and flag B is always the complement of flag A.
- R3: The data bits are inverted when the lane's running sum is nonzero and has the same sign as the disparity of the uninverted word (2 x ones - 7). A running sum of zero never inverts.
- R4: The running sum of each lane starts at zero after reset. After each word it changes by the disparity of the full 9-bit word as sent.
- R5: On every data lane, the running +1/-1 sum measured after every serial bit (bit 8 first) stays within +/-10.
- R6: The clock lane word is 9'h1E0 (four high bits) and 9'h1F0 (five high bits) in alternation. The first word after reset is 9'h1E0.
- R7: On the clock lane, the running +1/-1 sum after every serial bit stays within +/-5, and any two consecutive clock words hold nine ones in total.
- R8: While reset is high, every output is zero. An input word appears on the outputs one clock edge after it is sampled.
- R9: Taking bits 6..0 of a lane word and XOR-ing them with flag A gives back the input group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| word_i | input | 21 | Parallel data word, sampled every clock |
| lanes_o | output | 27 | Three 9-bit encoded lane words, lane k at bits 9k+8..9k |
| clk_lane_o | output | 9 | Clock lane pattern for the current period |

## Verification
A hand-worked sequence drives all-ones, all-zeros, near-balanced and single-bit groups into the three lanes at once, with a different history on each lane. This separates a correct sign comparison from an inverted one, from a rule that ignores a zero sum, and from lane swaps. A reset in the middle of a stream, followed by repeated all-ones words, shows whether the running sum and the clock phase really restart. A long pseudo-random stream is then checked bit by bit against the +/-10 and +/-5 bounds and against restoration of the data. This catches update errors that only show after many words.

// File: rtl/dcb_pkg.sv
package dcb_pkg;

    localparam int LANE_DATA_W  = 7;
    localparam int LANE_W       = LANE_DATA_W + 2;
    localparam int NUM_LANES    = 3;
    localparam int SUM_W        = $clog2(LANE_W + 1) + 2;
    localparam int MAX_DSV_DATA = 10;
    localparam int MAX_DSV_CLK  = 5;
    localparam int CLK_HI_SHORT = LANE_W / 2;
    localparam int CLK_HI_LONG  = LANE_W - CLK_HI_SHORT;

    typedef logic [LANE_DATA_W-1:0] data_t;
    typedef logic signed [SUM_W-1:0] sum_t;

    typedef struct packed {
        logic  flag_a;
        logic  flag_b;
        data_t payload;
    } lane_word_t;

    // Ones minus zeros of a data group
    function automatic int data_disp(data_t d);
        return 2 * $countones(d) - LANE_DATA_W;
    endfunction

    // Ones minus zeros of a full lane word
    function automatic int word_disp(logic [LANE_W-1:0] w);
        return 2 * $countones(w) - LANE_W;
    endfunction

    // Largest magnitude of the running sum while a word is shifted out MSB first
    function automatic int prefix_peak(int start, logic [LANE_W-1:0] w);
        int acc;
        int pk;
        acc = start;
        pk  = (start < 0) ? -start : start;
        for (int i = LANE_W - 1; i >= 0; i--) begin
            acc = acc + (w[i] ? 1 : -1);
            if (acc > pk)  pk = acc;
            if (-acc > pk) pk = -acc;
        end
        return pk;
    endfunction

endpackage

// File: rtl/dcb_lane_enc.sv
module dcb_lane_enc
    import dcb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  data_t      data_i,
    output lane_word_t word_o
);

    sum_t       rs_q;
    sum_t       rs_d;
    sum_t       cand;
    logic       inv;
    lane_word_t word_d;
    logic       live_q;

    always_comb begin
        cand           = sum_t'(data_disp(data_i));
        inv            = (rs_q != '0) && (rs_q[SUM_W-1] == cand[SUM_W-1]);
        word_d.flag_a  = inv;
        word_d.flag_b  = ~inv;
        word_d.payload = inv ? ~data_i : data_i;
        rs_d           = inv ? (rs_q - cand) : (rs_q + cand);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rs_q   <= '0;
            word_o <= '0;
            live_q <= 1'b0;
        end else begin
            rs_q   <= rs_d;
            word_o <= word_d;
            live_q <= 1'b1;
        end
    end

    AST_FLAG_PAIR: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (word_o.flag_a != word_o.flag_b)); // R2

    AST_SUM_TRACK: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (int'(rs_q) == int'($past(rs_q)) + word_disp(word_o))); // R4

    AST_BOUNDARY_SUM: assert property (@(posedge clk) disable iff (rst)
        (rs_q <= sum_t'(LANE_DATA_W)) && (rs_q >= -sum_t'(LANE_DATA_W))); // R3

    AST_DATA_PEAK: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (prefix_peak(int'($past(rs_q)), word_o) <= MAX_DSV_DATA)); // R5

endmodule

// File: rtl/dcb_clk_lane.sv
module dcb_clk_lane
    import dcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [LANE_W-1:0] word_o
);

    logic              phase_q;
    logic [LANE_W-1:0] pat;
    logic              live_q;
    sum_t              ck_acc_q;

    always_comb begin
        for (int i = 0; i < LANE_W; i++) begin
            pat[LANE_W-1-i] = phase_q ? (i < CLK_HI_LONG) : (i < CLK_HI_SHORT);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= 1'b0;
            word_o  <= '0;
            live_q  <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
            word_o  <= pat;
            live_q  <= 1'b1;
        end
    end

    // Accumulated disparity of clock words already emitted, for the bound check
    always_ff @(posedge clk) begin
        if (rst) begin
            ck_acc_q <= '0;
        end else if (live_q) begin
            ck_acc_q <= ck_acc_q + sum_t'(word_disp(word_o));
        end
    end

    AST_CLK_ONES: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (($countones(word_o) == CLK_HI_SHORT) || ($countones(word_o) == CLK_HI_LONG))); // R6

    AST_CLK_PAIR: assert property (@(posedge clk) disable iff (rst)
        (live_q && $past(live_q)) |-> ($countones(word_o) + $countones($past(word_o)) == LANE_W)); // R7

    AST_CLK_PEAK: assert property (@(posedge clk) disable iff (rst)
        live_q |-> (prefix_peak(int'(ck_acc_q), word_o) <= MAX_DSV_CLK)); // R7

endmodule

// File: rtl/dcb_lane_encoder.sv
module dcb_lane_encoder
    import dcb_pkg::*;
#(
    parameter int LANES = NUM_LANES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LANES*LANE_DATA_W-1:0]  word_i,
    output logic [LANES*LANE_W-1:0]       lanes_o,
    output logic [LANE_W-1:0]             clk_lane_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_word_t w;

        dcb_lane_enc u_enc (
            .clk    (clk),
            .rst    (rst),
            .data_i (word_i[g*LANE_DATA_W +: LANE_DATA_W]),
            .word_o (w)
        );

        assign lanes_o[g*LANE_W +: LANE_W] = w;
    end

    dcb_clk_lane u_clk (
        .clk    (clk),
        .rst    (rst),
        .word_o (clk_lane_o)
    );

endmodule

// File: tb/dcb_lane_encoder_tb.sv
module dcb_lane_encoder_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [20:0] word_i = '0;
    logic [26:0] lanes_o;
    logic [8:0]  clk_lane_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    dcb_lane_encoder dut_i (
        .clk        (clk),
        .rst        (rst),
        .word_i     (word_i),
        .lanes_o    (lanes_o),
        .clk_lane_o (clk_lane_o)
    );

    // {inv lane2, inv lane1, inv lane0, lane2 data, lane1 data, lane0 data}
    localparam logic [23:0] VECS [8] = '{
        {3'b000, 7'h3F, 7'h00, 7'h7F},
        {3'b111, 7'h3F, 7'h00, 7'h7F},
        {3'b000, 7'h40, 7'h01, 7'h7F},
        {3'b110, 7'h40, 7'h03, 7'h00},
        {3'b010, 7'h7F, 7'h07, 7'h01},
        {3'b000, 7'h00, 7'h7E, 7'h7F},
        {3'b011, 7'h7F, 7'h55, 7'h0F},
        {3'b000, 7'h00, 7'h2A, 7'h70}
    };

    function automatic logic [8:0] mk_word(logic [6:0] d, logic inv);
        return {inv, ~inv, inv ? ~d : d};
    endfunction

    function automatic logic [26:0] mk_lanes(logic [20:0] d, logic [2:0] inv);
        return {mk_word(d[20:14], inv[2]), mk_word(d[13:7], inv[1]), mk_word(d[6:0], inv[0])};
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(logic [20:0] d);
        word_i = d;
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int   s [3];
        int   cs;
        int   pk;
        logic [20:0] lfsr;

        // R8: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R8 reset lanes", 32'(lanes_o), 32'h0);
        check("R8 reset clk lane", 32'(clk_lane_o), 32'h0);

        // Table walk: R1 mapping, R2 flags, R3 decision, R4 sum history, R6 clock lane
        rst = 1'b0;
        for (int i = 0; i < 8; i++) begin
            step(VECS[i][20:0]);
            check("R1/R3/R4 table lanes", 32'(lanes_o), 32'(mk_lanes(VECS[i][20:0], VECS[i][23:21])));
            check("R6 table clk lane", 32'(clk_lane_o), (i % 2 == 0) ? 32'h1E0 : 32'h1F0);
        end

        // R4: reset mid-stream clears the running sums and clock phase
        step({3{7'h7F}});
        rst = 1'b1;
        step('0);
        check("R8 reset mid-stream", 32'(lanes_o), 32'h0);
        rst = 1'b0;
        step({3{7'h7F}});
        check("R4 sum cleared by reset", 32'(lanes_o), 32'(mk_lanes({3{7'h7F}}, 3'b000)));
        check("R6 first clk word after reset", 32'(clk_lane_o), 32'h1E0);
        step({3{7'h7F}});
        check("R3 same sign inverts", 32'(lanes_o), 32'(mk_lanes({3{7'h7F}}, 3'b111)));
        check("R6 second clk word", 32'(clk_lane_o), 32'h1F0);
        step({3{7'h00}});
        check("R3 zero sum never inverts", 32'(lanes_o), 32'(mk_lanes({3{7'h00}}, 3'b000)));

        // Long pseudo-random run from a fresh reset: R5, R7, R9, R2
        rst = 1'b1;
        step('0);
        rst = 1'b0;
        s    = '{0, 0, 0};
        cs   = 0;
        lfsr = 21'h1ACE5;
        for (int n = 0; n < 400; n++) begin
            lfsr = {lfsr[19:0], lfsr[20] ^ lfsr[18]};
            step((n % 37 == 5) ? {3{7'h7F}} : (n % 41 == 9) ? 21'h0 : lfsr);
            for (int k = 0; k < 3; k++) begin
                logic [8:0] w;
                w  = lanes_o[9*k +: 9];
                pk = 0;
                for (int b = 8; b >= 0; b--) begin
                    s[k] += w[b] ? 1 : -1;
                    if (s[k] > pk)  pk = s[k];
                    if (-s[k] > pk) pk = -s[k];
                end
                check("R5 data lane peak within 10", 32'(pk <= 10), 32'h1);
                check("R2 flags complementary", 32'(w[8] ^ w[7]), 32'h1);
                check("R9 data restored", 32'(w[6:0] ^ {7{w[8]}}), 32'(word_i[7*k +: 7]));
            end
            pk = 0;
            for (int b = 8; b >= 0; b--) begin
                cs += clk_lane_o[b] ? 1 : -1;
                if (cs > pk)  pk = cs;
                if (-cs > pk) pk = -cs;
            end
            check("R7 clock lane peak within 5", 32'(pk <= 5), 32'h1);
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule